// File: doc/BRIEF.md
# Shared-Line Address/Data Bus Peripheral

This block connects to a microcontroller's external expansion bus. The bus has sixteen lines that carry the address in one phase and the data in the other. A phase strobe, called E here, picks the phase: while E is low the lines hold an address, and while E is high they hold data. The block pulls the address out of that stream and holds it for the data phase. It decodes a two-byte window and keeps one byte-wide register at each address of the window. The processor can write these registers and read them back in one-byte or two-byte transfers.

The block also presents the demultiplexed bus to downstream memory-style devices. It outputs a held address, the last transferred data word, an active-low select and an active-low write enable. The shared lines are split into an input vector, an output vector and one output enable. All bus inputs are sampled by a fast system clock through a synchronizer. Address and data are delayed by the same number of stages, so every decision uses a consistent snapshot of the bus. The bus has no back-pressure: the master sets the pace, and the block follows every cycle.

Top module: `mux_bus_slave`

## Requirements
- R1: Reset gives cs_n=1, we_n=1, ad_oe=0, addr_out=0, data_out=0, and clears both registers, so a word read then returns 0x0000.
- R2: addr_out follows the address on ad_in during the E-low phase. It holds that value unchanged for the whole E-high phase, even when ad_in changes.
- R3: cs_n goes low only during the E-high phase of a cycle whose held address is 0x4000 or 0x4001. For any other address it stays high.
- R4: A write (bus_rw=0) with bus_wide_n=0 at 0x4000 stores ad_in[15:8] in the register at 0x4000 and ad_in[7:0] in the register at 0x4001. The data is taken as it stood just before E fell.
- R5: A one-byte write (bus_wide_n=1) at 0x4000 changes only the register at 0x4000, using bits 15:8.
- R6: A write at 0x4001, one-byte or two-byte, changes only the register at 0x4001, using bits 7:0.
- R7: During the E-high phase of a read (bus_rw=1) in the window, ad_oe=1 and ad_out = {reg@0x4000, reg@0x4001}. The drive stays on through the first system clock after E falls and is off by the second.
- R8: A cycle outside the window never drives the lines and changes neither register.
- R9: we_n goes low only during the E-high phase of a write in the window. It is never low while ad_oe is high.
- R10: At each fall of E, data_out takes the word that was on the bus: the driven register word for a read in the window, and otherwise the value on ad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than E |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Phase strobe: low means address phase, high means data phase |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wide_n | input | 1 | 0 = two-byte transfer, 1 = one-byte transfer |
| ad_in | input | 16 | Shared lines as seen by the block |
| ad_out | output | 16 | Value the block drives onto the shared lines |
| ad_oe | output | 1 | Enable for ad_out onto the shared lines |
| addr_out | output | 16 | Demultiplexed, held address |
| data_out | output | 16 | Word transferred in the last completed cycle |
| cs_n | output | 1 | Active-low window select |
| we_n | output | 1 | Active-low write enable |

## Verification
Two functions can fall in the same system-clock cycle. When E falls, the block captures write data and turns off its read drive, and in that same cycle the address register starts following the lines again. The data capture must therefore still use the frozen address. The bench provokes this by putting a fresh address on ad_in at the very moment E falls, with a different address in each of the two cycles. It then judges the result by reading the registers back (R4, R6, R8) and by sampling ad_oe in the first and second clocks after the fall (R7).

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int BYTE_W = 8;

  // Byte lanes touched by a write: bit 1 = upper lane (even address), bit 0 = lower lane.
  function automatic logic [1:0] lane_mask(input logic a0, input logic wide_n);
    if (a0)           return 2'b01;
    else if (!wide_n) return 2'b11;
    else              return 2'b10;
  endfunction
endpackage

// File: rtl/mbs_delay.sv
module mbs_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [DEPTH-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[DEPTH-2:0], din};
  end

  assign cur = st[DEPTH-2];
  assign prv = st[DEPTH-1];
endmodule

// File: rtl/mbs_decode.sv
module mbs_decode #(
  parameter int          AW   = 16,
  parameter logic [15:0] BASE = 16'h4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_cur,
  input  logic [AW-1:0] ad_cur,
  output logic [AW-1:0] addr_q,
  output logic          hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (!e_cur) addr_q <= ad_cur;
  end

  assign hit = (addr_q[AW-1:1] == BASE[AW-1:1]);

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (e_cur && $past(e_cur)) |-> $stable(addr_q)); // R2
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    lanes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);
  import mbs_pkg::*;
  localparam int NB = DW / BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                byte_q <= '0;
      else if (wr_en && lanes[b]) byte_q <= wdata[b*BYTE_W +: BYTE_W];
    end
    assign rd_word[b*BYTE_W +: BYTE_W] = byte_q;
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_word)); // R8
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int          AW   = 16,
  parameter int          DW   = 16,
  parameter logic [15:0] BASE = 16'h4000,
  parameter int          SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_e,
  input  logic          bus_rw,
  input  logic          bus_wide_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out,
  output logic          cs_n,
  output logic          we_n
);
  import mbs_pkg::*;
  localparam int DEPTH = SYNC + 1;

  logic [2:0]    ctl_cur, ctl_prv;
  logic [DW-1:0] ad_cur, ad_prv;

  // Control and shared lines go through equal-length pipelines so they stay aligned.
  mbs_delay #(.W(3), .DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .din({bus_e, bus_rw, bus_wide_n}),
    .cur(ctl_cur), .prv(ctl_prv));

  mbs_delay #(.W(DW), .DEPTH(DEPTH)) u_ad (
    .clk(clk), .rst_n(rst_n), .din(ad_in), .cur(ad_cur), .prv(ad_prv));

  logic e_cur, rw_cur, wide_cur, e_prv, rw_prv, wide_prv;
  assign {e_cur, rw_cur, wide_cur} = ctl_cur;
  assign {e_prv, rw_prv, wide_prv} = ctl_prv;

  logic e_fall;
  assign e_fall = e_prv && !e_cur;

  logic [AW-1:0] addr_q;
  logic          hit;
  mbs_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .e_cur(e_cur), .ad_cur(ad_cur[AW-1:0]),
    .addr_q(addr_q), .hit(hit));

  logic          wr_en;
  logic [1:0]    lanes;
  logic [DW-1:0] rd_word;
  assign wr_en = e_fall && hit && !rw_prv;
  assign lanes = lane_mask(addr_q[0], wide_prv);

  mbs_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lanes(lanes),
    .wdata(ad_prv), .rd_word(rd_word));

  logic data_phase;
  assign data_phase = e_cur && hit;
  assign cs_n   = !data_phase;
  assign we_n   = !(data_phase && !rw_cur);
  assign ad_oe  = data_phase && rw_cur;
  assign ad_out = rd_word;

  logic [DW-1:0] data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (e_fall) data_q <= (hit && rw_prv) ? rd_word : ad_prv;
  end
  assign data_out = data_q;
  assign addr_out = addr_q;

  AST_NO_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !e_cur |-> !ad_oe); // R7
  AST_OE_OFF_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    e_fall |-> !ad_oe); // R7
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n); // R9
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !we_n)); // R9
  AST_WIDTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (e_cur && $past(e_cur)) |-> $stable(wide_cur)); // R4
endmodule

// File: tb/mux_bus_slave_tb.sv
module mux_bus_slave_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_e = 0, bus_rw = 1, bus_wide_n = 1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out, addr_out, data_out;
  logic ad_oe, cs_n, we_n;

  always #2 clk = ~clk;

  mux_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rw(bus_rw),
    .bus_wide_n(bus_wide_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_out(addr_out), .data_out(data_out), .cs_n(cs_n), .we_n(we_n));

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input [15:0] act, input [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // addr, rw, wide_n, data-phase word, expected read word, in-window
  localparam int NV = 12;
  localparam logic [50:0] VEC [NV] = '{
    {16'h4000, 1'b0, 1'b0, 16'hA1B2, 16'h0000, 1'b1},
    {16'h4000, 1'b1, 1'b0, 16'hDEAD, 16'hA1B2, 1'b1},
    {16'h4000, 1'b0, 1'b1, 16'h5C77, 16'h0000, 1'b1},
    {16'h4001, 1'b1, 1'b1, 16'hDEAD, 16'h5CB2, 1'b1},
    {16'h4001, 1'b0, 1'b1, 16'h1234, 16'h0000, 1'b1},
    {16'h4000, 1'b1, 1'b0, 16'hDEAD, 16'h5C34, 1'b1},
    {16'h4002, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0},
    {16'h3FFF, 1'b0, 1'b1, 16'hEEEE, 16'h0000, 1'b0},
    {16'h4000, 1'b1, 1'b0, 16'hDEAD, 16'h5C34, 1'b1},
    {16'hC000, 1'b1, 1'b0, 16'hBEEF, 16'h0000, 1'b0},
    {16'h4001, 1'b0, 1'b0, 16'h9988, 16'h0000, 1'b1},
    {16'h4000, 1'b1, 1'b0, 16'hDEAD, 16'h5C88, 1'b1}
  };

  task automatic bus_cycle(input [15:0] a, input rw, input wn, input [15:0] wd,
                           output bit cs_seen, output bit we_seen, output bit oe_seen,
                           output logic [15:0] rd, output logic [15:0] a_lo,
                           output logic [15:0] a_hi, output logic [15:0] dout);
    @(negedge clk);
    bus_e = 0; ad_in = a; bus_rw = rw; bus_wide_n = wn;
    repeat (6) @(negedge clk);
    a_lo = addr_out;
    bus_e = 1; ad_in = wd;
    cs_seen = 0; we_seen = 0; oe_seen = 0; rd = '0;
    repeat (6) begin
      @(negedge clk);
      if (!cs_n) cs_seen = 1;
      if (!we_n) we_seen = 1;
      if (ad_oe) begin oe_seen = 1; rd = ad_out; end
    end
    a_hi = addr_out;
    bus_e = 0; ad_in = 16'h0BAD;   // new address appears exactly as E falls
    repeat (4) @(negedge clk);
    dout = data_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit cs_s, we_s, oe_s;
    logic [15:0] rd, a_lo, a_hi, dout;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1 && we_n == 1 && ad_oe == 0, "R1 ctl", {cs_n, we_n, ad_oe}, 16'h6);
    chk(addr_out == 0, "R1 addr", addr_out, 16'h0);
    chk(data_out == 0, "R1 data", data_out, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] va, vw, vx; logic vr, vn, vh;
      {va, vr, vn, vw, vx, vh} = VEC[i];
      bus_cycle(va, vr, vn, vw, cs_s, we_s, oe_s, rd, a_lo, a_hi, dout);
      chk(a_lo == va, "R2 addr low phase", a_lo, va);
      chk(a_hi == va, "R2 addr held high phase", a_hi, va);
      chk(cs_s == vh, "R3 select", cs_s, vh);
      chk(we_s == (vh && !vr), "R9 write enable", we_s, vh && !vr);
      chk(oe_s == (vh && vr), "R7/R8 drive", oe_s, vh && vr);
      if (vh && vr) chk(rd == vx, "R4/R5/R6 read-back", rd, vx);
      chk(dout == ((vh && vr) ? vx : vw), "R10 data_out", dout, (vh && vr) ? vx : vw);
    end

    // R7: drive lasts one clock past the fall, gone by the second
    @(negedge clk); bus_e = 0; ad_in = 16'h4000; bus_rw = 1; bus_wide_n = 0;
    repeat (6) @(negedge clk); bus_e = 1; ad_in = 16'h1111;
    repeat (6) @(negedge clk);
    chk(ad_oe == 1, "R7 drive on", ad_oe, 1);
    bus_e = 0; ad_in = 16'h4001;
    @(negedge clk);
    chk(ad_oe == 1, "R7 drive held first clock", ad_oe, 1);
    @(negedge clk);
    chk(ad_oe == 0, "R7 drive off second clock", ad_oe, 0);
    repeat (4) @(negedge clk);

    // R1: reset clears registers
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    bus_cycle(16'h4000, 1, 0, 16'hDEAD, cs_s, we_s, oe_s, rd, a_lo, a_hi, dout);
    chk(oe_s == 1 && rd == 16'h0000, "R1 regs cleared", rd, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule